// File: doc/BRIEF.md
# Shared Internal Bus Arbiter

This block arbitrates a wide on-chip shared bus driven by several logic blocks. The bus is built from 9-bit bytes, each holding 8 data bits and an even-parity bit. At run time the bytes are grouped into lanes of one, two or four bytes, which gives 9-, 18- or 36-bit lanes. With the default of twelve bytes the bus is 108 bits wide. The true tristate drivers are modelled as a multiplexer plus a hold register.

Each requester raises a per-byte drive `valid` together with its data. The first requester to ask for a free lane is granted ownership of it, and it keeps that ownership until it stops asking. Ownership is shown by `ready` on every byte of the lane. The data of a byte appears on the bus only in cycles where that requester has both `valid` and `ready` high on it. A requester that is held back must keep `valid` and its data stable and wait. No requester loses its place because another one asks. When no requester drives a byte, the byte keeps the last value that was on it.

Top module: `sbus_arbiter`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is asserted and in the first cycle after it, `bus_data` is all zeros, and `bus_driven`, `req_ready` and `parity_err` are all zero.
- R2: Lane mode encoding, counted from byte 0 with lanes aligned to their own size: 0 gives one-byte (9-bit) lanes, 1 gives two-byte (18-bit) lanes, and 2 or 3 gives four-byte (36-bit) lanes. A request on any byte of a lane competes for the whole lane, and a grant raises `ready` on every byte of that lane.
- R3: At a clock edge where a lane is free and one or more requesters ask for it, the requester with the lowest index becomes the owner. From the next cycle on, its `ready` is high on the lane. At most one requester holds `ready` on any byte.
- R4: No pre-emption. While the owner keeps any `valid` high within its lane, it stays the owner, and no other requester gets `ready` on that lane, even one with a lower index.
- R5: At an edge where the owner has no `valid` within its lane, the lane becomes free. No requester has `ready` on it in the following cycle. A waiting requester is granted at the edge after that, which makes a handover take one cycle.
- R6: A byte is driven when its owner's `valid` on that byte is high. In that case `bus_driven` is 1 for the byte and the byte of `bus_data` equals the owner's data for that byte, in the same cycle.
- R7: A byte that is not driven shows the last value driven onto it, or zero if it has not been driven since reset.
- R8: Byte b sits at `bus_data[9b+8:9b]` with the parity bit at position 8. `parity_err[b]` is 1 exactly when the byte is driven and the XOR of its 9 bits is 1.
- R9: `lane_mode` is registered. At an edge where it differs from the registered value, the new mode is taken and every lane is freed. The new grouping applies in the next cycle, and grants follow at the edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_mode | input | 2 | Lane partition select |
| req_valid | input | NUM_REQ*NUM_BYTES | Per-requester, per-byte drive enable, bit r*NUM_BYTES+b |
| req_data | input | NUM_REQ*NUM_BYTES*9 | Per-requester bus data, byte b of requester r at offset (r*NUM_BYTES+b)*9 |
| req_ready | output | NUM_REQ*NUM_BYTES | Lane ownership per requester and byte, same indexing as req_valid |
| bus_data | output | NUM_BYTES*9 | Resolved bus value |
| bus_driven | output | NUM_BYTES | Byte is driven this cycle |
| parity_err | output | NUM_BYTES | Driven byte has odd parity |

## Verification
The bench builds the block with its default sizes: four requesters and twelve bytes, the full 108-line bus. Four requesters allow three-way same-cycle ties and a lower-index late arrival that must not pre-empt the owner. Twelve bytes divide into one-, two- and four-byte lanes, so every partition mode is reached, including mode changes while a lane is owned.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

  // Width of one bus byte: 8 data bits plus one parity bit
  localparam int unsigned BYTE_W = 9;

  typedef enum logic [1:0] {
    LANE_9   = 2'd0,
    LANE_18  = 2'd1,
    LANE_36  = 2'd2,
    LANE_36B = 2'd3
  } lane_mode_e;

  // Number of bytes grouped into one lane for a given mode
  function automatic int unsigned lane_bytes(lane_mode_e m);
    case (m)
      LANE_9:  return 1;
      LANE_18: return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/sbus_lane_req.sv
// Folds per-byte drive requests into per-lane requests, seen from every byte.
module sbus_lane_req
  import sbus_pkg::*;
#(
  parameter int unsigned NUM_REQ   = 4,
  parameter int unsigned NUM_BYTES = 12   // must be a multiple of 4
) (
  input  lane_mode_e                       mode,
  input  logic [NUM_REQ*NUM_BYTES-1:0]     byte_req,
  output logic [NUM_REQ*NUM_BYTES-1:0]     lane_req
);

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
      localparam int unsigned BASE = r * NUM_BYTES;
      localparam int unsigned P2   = BASE + (b / 2) * 2;
      localparam int unsigned P4   = BASE + (b / 4) * 4;
      always_comb begin
        case (mode)
          LANE_9:  lane_req[BASE+b] = byte_req[BASE+b];
          LANE_18: lane_req[BASE+b] = byte_req[P2] | byte_req[P2+1];
          default: lane_req[BASE+b] = byte_req[P4]   | byte_req[P4+1] |
                                      byte_req[P4+2] | byte_req[P4+3];
        endcase
      end
    end
  end

endmodule

// File: rtl/sbus_lane_owner.sv
// First-come ownership register for one byte position.
module sbus_lane_owner #(
  parameter int unsigned NUM_REQ = 4,
  localparam int unsigned ID_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [NUM_REQ-1:0] lane_req,
  output logic               owned,
  output logic [ID_W-1:0]    owner_id,
  output logic               owner_req
);

  logic [ID_W-1:0] pick;
  logic            any_req;

  assign any_req   = |lane_req;
  assign owner_req = owned & lane_req[owner_id];

  // lowest index wins a same-cycle tie
  always_comb begin
    pick = '0;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (lane_req[i]) pick = ID_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owned    <= 1'b0;
      owner_id <= '0;
    end else if (flush) begin
      owned    <= 1'b0;
    end else if (owned) begin
      if (!owner_req) owned <= 1'b0;   // release: lane idle for one cycle
    end else if (any_req) begin
      owned    <= 1'b1;
      owner_id <= pick;
    end
  end

endmodule

// File: rtl/sbus_byte_drive.sv
// Bus byte resolution: owner mux, hold register and parity check.
module sbus_byte_drive
  import sbus_pkg::*;
#(
  parameter int unsigned NUM_REQ = 4,
  localparam int unsigned ID_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      owned,
  input  logic [ID_W-1:0]           owner_id,
  input  logic [NUM_REQ-1:0]        byte_valid,
  input  logic [NUM_REQ*BYTE_W-1:0] byte_data,
  output logic [BYTE_W-1:0]         bus_byte,
  output logic                      driven,
  output logic                      perr
);

  logic [BYTE_W-1:0] hold_q;
  logic [BYTE_W-1:0] sel_data;

  always_comb begin
    sel_data = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (owner_id == ID_W'(i)) sel_data = byte_data[i*BYTE_W +: BYTE_W];
    end
  end

  assign driven   = owned & byte_valid[owner_id];
  assign bus_byte = driven ? sel_data : hold_q;
  assign perr     = driven & (^sel_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= bus_byte;
  end

endmodule

// File: rtl/sbus_arbiter.sv
// Shared internal bus arbiter, top level.
module sbus_arbiter
  import sbus_pkg::*;
#(
  parameter int unsigned NUM_REQ   = 4,
  parameter int unsigned NUM_BYTES = 12,  // multiple of 4
  localparam int unsigned BUS_W    = NUM_BYTES * BYTE_W,
  localparam int unsigned ID_W     = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [1:0]                     lane_mode,
  input  logic [NUM_REQ*NUM_BYTES-1:0]   req_valid,
  input  logic [NUM_REQ*BUS_W-1:0]       req_data,
  output logic [NUM_REQ*NUM_BYTES-1:0]   req_ready,
  output logic [BUS_W-1:0]               bus_data,
  output logic [NUM_BYTES-1:0]           bus_driven,
  output logic [NUM_BYTES-1:0]           parity_err
);

  lane_mode_e                      mode_q;
  logic                            mode_chg;
  logic [NUM_REQ*NUM_BYTES-1:0]    lane_req;
  logic [NUM_BYTES-1:0]            owned;
  logic [NUM_BYTES-1:0]            owner_req;
  logic [NUM_BYTES*ID_W-1:0]       owner_id_flat;

  assign mode_chg = (lane_mode != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= LANE_9;
    else        mode_q <= lane_mode_e'(lane_mode);
  end

  sbus_lane_req #(
    .NUM_REQ  (NUM_REQ),
    .NUM_BYTES(NUM_BYTES)
  ) u_lane_req (
    .mode    (mode_q),
    .byte_req(req_valid),
    .lane_req(lane_req)
  );

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    logic [NUM_REQ-1:0]        col_req;
    logic [NUM_REQ-1:0]        col_valid;
    logic [NUM_REQ*BYTE_W-1:0] col_data;
    logic [ID_W-1:0]           oid;

    for (genvar r = 0; r < NUM_REQ; r++) begin : g_col
      assign col_req[r]   = lane_req[r*NUM_BYTES + b];
      assign col_valid[r] = req_valid[r*NUM_BYTES + b];
      assign col_data[r*BYTE_W +: BYTE_W] =
        req_data[(r*NUM_BYTES + b)*BYTE_W +: BYTE_W];
      assign req_ready[r*NUM_BYTES + b] = owned[b] & (oid == ID_W'(r));
    end

    sbus_lane_owner #(.NUM_REQ(NUM_REQ)) u_owner (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (mode_chg),
      .lane_req (col_req),
      .owned    (owned[b]),
      .owner_id (oid),
      .owner_req(owner_req[b])
    );

    assign owner_id_flat[b*ID_W +: ID_W] = oid;

    sbus_byte_drive #(.NUM_REQ(NUM_REQ)) u_drive (
      .clk       (clk),
      .rst_n     (rst_n),
      .owned     (owned[b]),
      .owner_id  (oid),
      .byte_valid(col_valid),
      .byte_data (col_data),
      .bus_byte  (bus_data[b*BYTE_W +: BYTE_W]),
      .driven    (bus_driven[b]),
      .perr      (parity_err[b])
    );
  end

endmodule

// File: rtl/sbus_arbiter_chk.sv
module sbus_arbiter_chk #(
  parameter int unsigned NUM_REQ   = 4,
  parameter int unsigned NUM_BYTES = 12,
  localparam int unsigned ID_W     = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int unsigned BW       = 9
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         mode_chg,
  input logic [NUM_BYTES-1:0]         owned,
  input logic [NUM_BYTES-1:0]         owner_req,
  input logic [NUM_BYTES*ID_W-1:0]    owner_id,
  input logic [NUM_REQ*NUM_BYTES-1:0] req_ready,
  input logic [NUM_BYTES*BW-1:0]      bus_data,
  input logic [NUM_BYTES-1:0]         bus_driven,
  input logic [NUM_BYTES-1:0]         parity_err
);

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_b
    logic [NUM_REQ-1:0] rcol;
    for (genvar r = 0; r < NUM_REQ; r++) begin : g_r
      assign rcol[r] = req_ready[r*NUM_BYTES + b];
    end

    // R4
    keep_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (owned[b] && owner_req[b] && !mode_chg) |=>
        (owned[b] && $stable(owner_id[b*ID_W +: ID_W])));

    // R5
    release_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (owned[b] && !owner_req[b] && !mode_chg) |=> !owned[b]);

    // R9
    mode_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_chg |=> !owned[b]);

    // R3
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rcol));

    // R6
    drive_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_driven[b] |-> (rcol != '0));

    // R7
    hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_driven[b] |-> (bus_data[b*BW +: BW] == $past(bus_data[b*BW +: BW])));

    // R8
    parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      parity_err[b] |-> (bus_driven[b] && (^bus_data[b*BW +: BW])));
  end

endmodule

bind sbus_arbiter sbus_arbiter_chk #(
  .NUM_REQ  (NUM_REQ),
  .NUM_BYTES(NUM_BYTES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_chg  (mode_chg),
  .owned     (owned),
  .owner_req (owner_req),
  .owner_id  (owner_id_flat),
  .req_ready (req_ready),
  .bus_data  (bus_data),
  .bus_driven(bus_driven),
  .parity_err(parity_err)
);

// File: tb/sbus_arbiter_bench.sv
module sbus_arbiter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NR = 4;
  localparam int NB = 12;
  localparam int BW = 9;
  localparam int BUS_W = NB * BW;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [1:0]           lane_mode = 2'd0;
  logic [NR*NB-1:0]     req_valid = '0;
  logic [NR*BUS_W-1:0]  req_data = '0;
  logic [NR*NB-1:0]     req_ready;
  logic [BUS_W-1:0]     bus_data;
  logic [NB-1:0]        bus_driven;
  logic [NB-1:0]        parity_err;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model state
  bit       m_own_v [NB];
  int       m_own_id[NB];
  logic [8:0] m_hold[NB];
  logic [1:0] m_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbus_arbiter #(.NUM_REQ(NR), .NUM_BYTES(NB)) u_sbus_arbiter (
    .clk(clk), .rst_n(rst_n), .lane_mode(lane_mode),
    .req_valid(req_valid), .req_data(req_data), .req_ready(req_ready),
    .bus_data(bus_data), .bus_driven(bus_driven), .parity_err(parity_err)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int grp(input logic [1:0] m);
    return (m == 2'd0) ? 1 : (m == 2'd1) ? 2 : 4;
  endfunction

  function automatic bit lreq(input int r, input int b);
    int g = grp(m_mode);
    int first = b - (b % g);
    bit v = 1'b0;
    for (int k = 0; k < g; k++) v |= req_valid[r*NB + first + k];
    return v;
  endfunction

  function automatic logic [8:0] rdata(input int r, input int b);
    return req_data[(r*NB + b)*BW +: BW];
  endfunction

  function automatic logic [8:0] mk_byte(input logic [7:0] d, input bit bad);
    return {(^d) ^ bad, d};
  endfunction

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin
      m_own_v[b] = 0; m_own_id[b] = 0; m_hold[b] = '0;
    end
    m_mode = 2'd0;
  endtask

  task automatic expect_now(output logic [BUS_W-1:0] eb, output logic [NB-1:0] ed,
                            output logic [NR*NB-1:0] er, output logic [NB-1:0] ep);
    eb = '0; ed = '0; er = '0; ep = '0;
    for (int b = 0; b < NB; b++) begin
      logic [8:0] v;
      v = m_hold[b];
      if (m_own_v[b]) begin
        er[m_own_id[b]*NB + b] = 1'b1;
        if (req_valid[m_own_id[b]*NB + b]) begin
          ed[b] = 1'b1;
          v = rdata(m_own_id[b], b);
          ep[b] = ^v;
        end
      end
      eb[b*BW +: BW] = v;
    end
  endtask

  task automatic model_edge();
    logic [BUS_W-1:0] eb; logic [NB-1:0] ed; logic [NR*NB-1:0] er; logic [NB-1:0] ep;
    bit nv[NB]; int nid[NB];
    expect_now(eb, ed, er, ep);
    for (int b = 0; b < NB; b++) begin
      m_hold[b] = eb[b*BW +: BW];
      nv[b] = m_own_v[b]; nid[b] = m_own_id[b];
      if (lane_mode != m_mode) nv[b] = 0;
      else if (m_own_v[b]) begin
        if (!lreq(m_own_id[b], b)) nv[b] = 0;
      end else begin
        for (int r = NR - 1; r >= 0; r--)
          if (lreq(r, b)) begin nv[b] = 1; nid[b] = r; end
      end
    end
    for (int b = 0; b < NB; b++) begin m_own_v[b] = nv[b]; m_own_id[b] = nid[b]; end
    m_mode = lane_mode;
  endtask

  // compare all outputs against the model, then advance one clock
  task automatic cyc();
    logic [BUS_W-1:0] eb; logic [NB-1:0] ed; logic [NR*NB-1:0] er; logic [NB-1:0] ep;
    #1;
    expect_now(eb, ed, er, ep);
    chk("R6/R7 bus_data", 128'(bus_data), 128'(eb));
    chk("R6 bus_driven", 128'(bus_driven), 128'(ed));
    chk("R3/R4/R5 req_ready", 128'(req_ready), 128'(er));
    chk("R8 parity_err", 128'(parity_err), 128'(ep));
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic set_req(input int r, input int b, input bit v, input logic [8:0] d);
    req_valid[r*NB + b] = v;
    req_data[(r*NB + b)*BW +: BW] = d;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    int seed;
    seed = 32'h5eed_0042;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 bus_data in reset", 128'(bus_data), 128'(0));
    chk("R1 req_ready in reset", 128'(req_ready), 128'(0));
    chk("R1 bus_driven in reset", 128'(bus_driven), 128'(0));
    rst_n = 1'b1;
    cyc();
    chk("R1 bus_data after reset", 128'(bus_data), 128'(0));

    // R3: three-way tie on byte 0, lowest index (1) wins
    set_req(1, 0, 1, mk_byte(8'hA5, 0));
    set_req(2, 0, 1, mk_byte(8'h3C, 0));
    set_req(3, 0, 1, mk_byte(8'h0F, 0));
    cyc();
    #1;
    chk("R3 tie winner ready", 128'(req_ready[1*NB]), 128'(1));
    chk("R3 tie losers ready", 128'({req_ready[2*NB], req_ready[3*NB]}), 128'(0));
    chk("R6 owner data on bus", 128'(bus_data[8:0]), 128'(mk_byte(8'hA5, 0)));

    // R4: lower index arrives later, no pre-emption
    set_req(0, 0, 1, mk_byte(8'h77, 0));
    cyc(); cyc();
    #1;
    chk("R4 late low index held off", 128'(req_ready[0]), 128'(0));
    chk("R4 owner kept", 128'(req_ready[1*NB]), 128'(1));

    // R5 and R7: owner releases, one idle cycle, bus holds
    set_req(1, 0, 0, mk_byte(8'hA5, 0));
    cyc();
    #1;
    chk("R5 idle after release", 128'({req_ready[0], req_ready[1*NB], req_ready[2*NB], req_ready[3*NB]}), 128'(0));
    chk("R7 held value", 128'(bus_data[8:0]), 128'(mk_byte(8'hA5, 0)));
    cyc();
    #1;
    chk("R5 next grant lowest", 128'(req_ready[0]), 128'(1));

    // R8: owner drives bad parity
    set_req(0, 0, 1, mk_byte(8'h77, 1));
    #1;
    chk("R8 bad parity flagged", 128'(parity_err[0]), 128'(1));
    set_req(0, 0, 1, mk_byte(8'h77, 0));
    #1;
    chk("R8 good parity clear", 128'(parity_err[0]), 128'(0));
    cyc();
    req_valid = '0;
    cyc(); cyc();

    // R2 and R9: switch to 36-bit lanes, request on byte 5 only
    lane_mode = 2'd2;
    set_req(3, 5, 1, mk_byte(8'h5A, 0));
    cyc();
    #1;
    chk("R9 no grant during mode change", 128'(req_ready), 128'(0));
    cyc();
    #1;
    chk("R2 whole 36-bit lane granted", 128'(req_ready[3*NB+4 +: 4]), 128'(4'hF));
    chk("R2 next lane untouched", 128'(req_ready[3*NB+8]), 128'(0));
    chk("R6 only valid byte driven", 128'(bus_driven[7:4]), 128'(4'b0010));

    // R9: mode change frees an owned lane, then 18-bit grouping
    lane_mode = 2'd1;
    cyc();
    #1;
    chk("R9 flush owner", 128'(req_ready[3*NB+5]), 128'(0));
    cyc();
    #1;
    chk("R2 18-bit lane granted", 128'(req_ready[3*NB+4 +: 3]), 128'(3'b011));
    req_valid = '0;
    cyc();

    // constrained random phase
    for (int t = 0; t < 4000; t++) begin
      for (int i = 0; i < NR*NB; i++) begin
        if (($urandom % 8) == 0) req_valid[i] = ~req_valid[i];
        if (($urandom % 4) == 0)
          req_data[i*BW +: BW] = mk_byte(8'($urandom), ($urandom % 8) == 0);
      end
      if (($urandom % 60) == 0) lane_mode = 2'($urandom);
      cyc();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule